// File: doc/BRIEF.md
# Peripheral Slot ROM Arbiter

This block sits on the CPU address bus of an 8-bit system with seven peripheral slots. It watches every access in the peripheral I/O and slot-firmware region and decides, for each one, whether the on-board firmware ROM answers or a card answers. A card is reached through one of three per-slot selects:

- a 16-register device select in the low I/O page;
- a 256-byte firmware page select;
- an expansion-window strobe for the shared 2 KB window at $C800–$CFFF.

The block also holds three mode bits:

- **ROM-all switch:** hands the whole slot range to internal ROM.
- **Slot-3 card switch:** lets the card in slot 3 answer its own page.
- **Window lock:** a sticky bit that hands the expansion window to internal ROM.

A slot-3 page access that the internal ROM serves sets the lock. Any access to $CFFF clears it.

The 2 KB window is shared by all the cards. It belongs to the slot whose firmware page was most recently selected. An access to $CFFF releases the window, so no card answers in it until a card's page is selected again.

All selects and offsets are combinational from the address, the access strobe and the current state. The three mode bits, the lock and the window owner change only at the rising clock edge that ends a valid access.

Top module: `slot_rom_arbiter`

## Requirements
- R1: After reset the ROM-all switch, the slot-3 card switch and the window lock are 0, and no slot owns the expansion window. So after reset a valid access in $C800–$CFFE asserts no select, and `rom_sel` is 0.
- R2: A valid write to $C006 or $C007 loads address bit 0 into the ROM-all switch. A read of either address leaves the switch unchanged.
- R3: A valid write to $C00A or $C00B loads address bit 0 into the slot-3 card switch.
- R4: For a valid access to $C100–$C7FF, the slot number is address bits [10:8] and `page_off` carries address bits [7:0].
  - With the ROM-all switch at 0, the access asserts `page_sel` bit n for slot n, unless R5 applies.
  - With the ROM-all switch at 1, the access asserts `rom_sel` and no page select.
- R5: While the slot-3 card switch is 0, a valid access to $C300–$C3FF asserts `rom_sel` and not `page_sel[3]`.
- R6: A valid access to $C300–$C3FF while the slot-3 card switch is 0 sets the window lock at the end of that access. This holds whatever the state of the ROM-all switch.
- R7: A valid read or write at $CFFF clears the window lock and releases window ownership at the end of that access. The $CFFF access itself asserts no expansion strobe.
- R8: A valid access to $C800–$CFFE asserts `rom_sel` when the ROM-all switch or the window lock is 1. Otherwise it asserts `xstrobe_sel` bit n for the owning slot n, with `xwin_off` equal to address bits [10:0]. If no slot owns the window, nothing is asserted.
- R9: The window owner is the last slot whose `page_sel` bit was asserted by a valid access. A page served by internal ROM does not change the owner.
- R10: A valid access to $C080–$C0FF asserts `dev_sel` bit a[6:4], with `dev_reg` equal to a[3:0]. Addresses $C000–$C07F assert no device select.
- R11: A valid read of $C015 asserts `stat_hit` and returns the ROM-all switch in `stat_data` bit 7. A valid read of $C017 returns the slot-3 card switch in bit 7. Bits 6:0 are 0 in both cases.
- R12: While `acc_valid` is 0, every select and `stat_hit` is 0 and no state bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A CPU access is on the bus this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | CPU address |
| rom_sel | output | 1 | Internal firmware ROM answers this access |
| page_sel | output | 8 | Per-slot firmware page select (bit 0 unused) |
| xstrobe_sel | output | 8 | Per-slot expansion-window strobe |
| dev_sel | output | 8 | Per-slot device-register select |
| page_off | output | 8 | Offset within a 256-byte page |
| xwin_off | output | 11 | Offset within the 2 KB window |
| dev_reg | output | 4 | Device register index |
| stat_hit | output | 1 | Status read is being served |
| stat_data | output | 8 | Status byte, mode bit in bit 7 |
| int_all | output | 1 | ROM-all switch |
| slot3_card | output | 1 | Slot-3 card switch |
| win_lock | output | 1 | Window lock |

## Verification
Selects, offsets and status data are due in the same cycle the address is presented. The bench samples them 1 ns after it drives the inputs on the falling edge, which is before the rising edge that ends the access. The switches, the lock and the window owner change at that rising edge. The bench therefore reads the state bits at the next falling edge, and it checks ownership through the strobe that a later window access produces. Vector-table rows are laid out so that each row's expected selects already include the state left by the rows before it.

// File: rtl/slotarb_pkg.sv
package slotarb_pkg;
  localparam int ADDR_W     = 16;
  localparam int NUM_SLOTS  = 8;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int PAGE_OFF_W = 8;
  localparam int XWIN_OFF_W = 11;
  localparam int DEV_OFF_W  = 4;
  localparam int DATA_W     = 8;

  // Fixed map points the decode relies on
  localparam logic [7:0]        IO_PAGE_HI  = 8'hC0;
  localparam logic [4:0]        SLOT_PG_HI  = 5'b11000;  // $C000-$C7FF
  localparam logic [4:0]        XWIN_HI     = 5'b11001;  // $C800-$CFFF
  localparam logic [ADDR_W-1:0] XWIN_LAST   = 16'hCFFF;
  localparam logic [6:0]        SW_INT_PAIR = 7'h03;     // $C006/$C007
  localparam logic [6:0]        SW_C3_PAIR  = 7'h05;     // $C00A/$C00B
  localparam logic [7:0]        ST_INT_LO   = 8'h15;
  localparam logic [7:0]        ST_C3_LO    = 8'h17;
  localparam logic [SLOT_W-1:0] SHARED_SLOT = SLOT_W'(3);

  typedef struct packed {
    logic              int_all;
    logic              slot3_card;
    logic              win_lock;
    logic              owner_vld;
    logic [SLOT_W-1:0] owner;
  } arb_state_t;

  typedef struct packed {
    logic              sw_int_wr;
    logic              sw_c3_wr;
    logic              sw_val;
    logic              lock_set;
    logic              lock_clr;
    logic              claim;
    logic [SLOT_W-1:0] claim_slot;
  } arb_event_t;
endpackage

// File: rtl/slotarb_decode.sv
module slotarb_decode
  import slotarb_pkg::*;
(
  input  logic                    valid_i,
  input  logic                    write_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  arb_state_t              st_i,
  output logic                    rom_sel_o,
  output logic [NUM_SLOTS-1:0]    page_sel_o,
  output logic [NUM_SLOTS-1:0]    xstrobe_sel_o,
  output logic [NUM_SLOTS-1:0]    dev_sel_o,
  output logic [PAGE_OFF_W-1:0]   page_off_o,
  output logic [XWIN_OFF_W-1:0]   xwin_off_o,
  output logic [DEV_OFF_W-1:0]    dev_reg_o,
  output arb_event_t              ev_o
);
  logic              in_io, in_slot_pg, in_xwin, at_last;
  logic [SLOT_W-1:0] slot;
  logic              c3_internal, page_card, win_internal;
  logic              take_page, take_xwin, take_dev;

  always_comb begin
    in_io        = addr_i[ADDR_W-1:8] == IO_PAGE_HI;
    in_slot_pg   = (addr_i[ADDR_W-1:11] == SLOT_PG_HI) && !in_io;
    in_xwin      = addr_i[ADDR_W-1:11] == XWIN_HI;
    at_last      = addr_i == XWIN_LAST;
    slot         = addr_i[10:8];
    c3_internal  = (slot == SHARED_SLOT) && !st_i.slot3_card;
    page_card    = in_slot_pg && !st_i.int_all && !c3_internal;
    win_internal = st_i.int_all || st_i.win_lock;

    take_page = valid_i && page_card;
    take_xwin = valid_i && in_xwin && !at_last && !win_internal && st_i.owner_vld;
    take_dev  = valid_i && in_io && addr_i[7];

    rom_sel_o = valid_i && ((in_slot_pg && !page_card) || (in_xwin && win_internal));

    page_off_o = addr_i[PAGE_OFF_W-1:0];
    xwin_off_o = addr_i[XWIN_OFF_W-1:0];
    dev_reg_o  = addr_i[DEV_OFF_W-1:0];

    ev_o.sw_int_wr  = valid_i && write_i && in_io && (addr_i[7:1] == SW_INT_PAIR);
    ev_o.sw_c3_wr   = valid_i && write_i && in_io && (addr_i[7:1] == SW_C3_PAIR);
    ev_o.sw_val     = addr_i[0];
    ev_o.lock_set   = valid_i && in_slot_pg && c3_internal;
    ev_o.lock_clr   = valid_i && at_last;
    ev_o.claim      = take_page;
    ev_o.claim_slot = slot;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign page_sel_o[s]    = take_page && (slot == SLOT_W'(s));
    assign xstrobe_sel_o[s] = take_xwin && (st_i.owner == SLOT_W'(s));
    assign dev_sel_o[s]     = take_dev && (addr_i[6:4] == SLOT_W'(s));
  end
endmodule

// File: rtl/slotarb_regs.sv
module slotarb_regs
  import slotarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  arb_event_t ev_i,
  output arb_state_t st_o
);
  arb_state_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      if (ev_i.sw_int_wr) st_q.int_all    <= ev_i.sw_val;
      if (ev_i.sw_c3_wr)  st_q.slot3_card <= ev_i.sw_val;
      if (ev_i.lock_clr) begin
        st_q.win_lock  <= 1'b0;
        st_q.owner_vld <= 1'b0;
      end else begin
        if (ev_i.lock_set) st_q.win_lock <= 1'b1;
        if (ev_i.claim) begin
          st_q.owner_vld <= 1'b1;
          st_q.owner     <= ev_i.claim_slot;
        end
      end
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/slotarb_status.sv
module slotarb_status
  import slotarb_pkg::*;
(
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              int_all_i,
  input  logic              slot3_card_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  logic in_io, is_int, is_c3;

  always_comb begin
    in_io  = addr_i[ADDR_W-1:8] == IO_PAGE_HI;
    is_int = in_io && (addr_i[7:0] == ST_INT_LO);
    is_c3  = in_io && (addr_i[7:0] == ST_C3_LO);
    hit_o  = valid_i && !write_i && (is_int || is_c3);
    data_o = '0;
    if (hit_o) data_o[DATA_W-1] = is_int ? int_all_i : slot3_card_i;
  end
endmodule

// File: rtl/slot_rom_arbiter.sv
module slot_rom_arbiter
  import slotarb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [ADDR_W-1:0]     acc_addr,
  output logic                  rom_sel,
  output logic [NUM_SLOTS-1:0]  page_sel,
  output logic [NUM_SLOTS-1:0]  xstrobe_sel,
  output logic [NUM_SLOTS-1:0]  dev_sel,
  output logic [PAGE_OFF_W-1:0] page_off,
  output logic [XWIN_OFF_W-1:0] xwin_off,
  output logic [DEV_OFF_W-1:0]  dev_reg,
  output logic                  stat_hit,
  output logic [DATA_W-1:0]     stat_data,
  output logic                  int_all,
  output logic                  slot3_card,
  output logic                  win_lock
);
  arb_state_t st;
  arb_event_t ev;

  slotarb_decode u_decode (
    .valid_i       (acc_valid),
    .write_i       (acc_write),
    .addr_i        (acc_addr),
    .st_i          (st),
    .rom_sel_o     (rom_sel),
    .page_sel_o    (page_sel),
    .xstrobe_sel_o (xstrobe_sel),
    .dev_sel_o     (dev_sel),
    .page_off_o    (page_off),
    .xwin_off_o    (xwin_off),
    .dev_reg_o     (dev_reg),
    .ev_o          (ev)
  );

  slotarb_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_i  (ev),
    .st_o  (st)
  );

  slotarb_status u_status (
    .valid_i      (acc_valid),
    .write_i      (acc_write),
    .addr_i       (acc_addr),
    .int_all_i    (st.int_all),
    .slot3_card_i (st.slot3_card),
    .hit_o        (stat_hit),
    .data_o       (stat_data)
  );

  assign int_all    = st.int_all;
  assign slot3_card = st.slot3_card;
  assign win_lock   = st.win_lock;
endmodule

// File: rtl/slotarb_checker.sv
module slotarb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [15:0] acc_addr,
  input logic        rom_sel,
  input logic [7:0]  page_sel,
  input logic [7:0]  xstrobe_sel,
  input logic [7:0]  dev_sel,
  input logic        stat_hit,
  input logic [7:0]  stat_data,
  input logic        int_all,
  input logic        slot3_card,
  input logic        win_lock
);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (page_sel == 8'h0 && xstrobe_sel == 8'h0 && dev_sel == 8'h0 && !rom_sel && !stat_hit));

  a_r12_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> ($stable(int_all) && $stable(slot3_card) && $stable(win_lock)));

  a_r4_one_page: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(page_sel) && $onehot0(xstrobe_sel) && $onehot0(dev_sel));

  a_r8_rom_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (page_sel == 8'h0 && xstrobe_sel == 8'h0));

  a_r2_switch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[15:1] == 15'h6003) |=> (int_all == $past(acc_addr[0])));

  a_r3_switch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[15:1] == 15'h6005) |=> (slot3_card == $past(acc_addr[0])));

  a_r6_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[15:8] == 8'hC3 && !slot3_card) |=> win_lock);

  a_r7_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr == 16'hCFFF) |=> !win_lock);

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr[15:11] == 5'b11001 && $past(acc_valid && acc_addr == 16'hCFFF))
      |-> (xstrobe_sel == 8'h0));

  a_r11_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hit |-> (stat_data[6:0] == 7'h0 && !acc_write));
endmodule

bind slot_rom_arbiter slotarb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .rom_sel(rom_sel), .page_sel(page_sel),
  .xstrobe_sel(xstrobe_sel), .dev_sel(dev_sel), .stat_hit(stat_hit),
  .stat_data(stat_data), .int_all(int_all), .slot3_card(slot3_card),
  .win_lock(win_lock)
);

// File: tb/tb_slot_rom_arbiter.sv
`timescale 1ns/1ps
module tb_slot_rom_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = 16'h0;
  logic        rom_sel, stat_hit, int_all, slot3_card, win_lock;
  logic [7:0]  page_sel, xstrobe_sel, dev_sel, page_off, stat_data;
  logic [10:0] xwin_off;
  logic [3:0]  dev_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slot_rom_arbiter dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .rom_sel(rom_sel), .page_sel(page_sel),
    .xstrobe_sel(xstrobe_sel), .dev_sel(dev_sel), .page_off(page_off),
    .xwin_off(xwin_off), .dev_reg(dev_reg), .stat_hit(stat_hit),
    .stat_data(stat_data), .int_all(int_all), .slot3_card(slot3_card),
    .win_lock(win_lock)
  );

  // Row: {req, write, addr, rom, page_sel, xstrobe_sel, dev_sel}.
  // The rows run in order from reset, and each row's expected value includes the state left by earlier rows.
  localparam int NV = 18;
  localparam logic [45:0] VEC [NV] = '{
    {4'd4,  1'b0, 16'hC600, 1'b0, 8'h40, 8'h00, 8'h00}, // R4 slot 6 page, R9 owner 6
    {4'd8,  1'b0, 16'hC800, 1'b0, 8'h00, 8'h40, 8'h00}, // R8 window -> slot 6
    {4'd10, 1'b0, 16'hC0E5, 1'b0, 8'h00, 8'h00, 8'h40}, // R10 device slot 6
    {4'd10, 1'b0, 16'hC0A0, 1'b0, 8'h00, 8'h00, 8'h04}, // R10 device slot 2
    {4'd5,  1'b0, 16'hC345, 1'b1, 8'h00, 8'h00, 8'h00}, // R5 internal slot-3 page, R6 sets lock
    {4'd8,  1'b0, 16'hCA00, 1'b1, 8'h00, 8'h00, 8'h00}, // R8 lock -> ROM
    {4'd7,  1'b0, 16'hCFFF, 1'b1, 8'h00, 8'h00, 8'h00}, // R7 release
    {4'd7,  1'b0, 16'hC900, 1'b0, 8'h00, 8'h00, 8'h00}, // R7 no owner left
    {4'd3,  1'b1, 16'hC00B, 1'b0, 8'h00, 8'h00, 8'h00}, // R3 slot-3 card on
    {4'd5,  1'b0, 16'hC310, 1'b0, 8'h08, 8'h00, 8'h00}, // R5 card page 3
    {4'd9,  1'b0, 16'hCC00, 1'b0, 8'h00, 8'h08, 8'h00}, // R9 owner 3
    {4'd2,  1'b1, 16'hC007, 1'b0, 8'h00, 8'h00, 8'h00}, // R2 ROM-all on
    {4'd4,  1'b0, 16'hC200, 1'b1, 8'h00, 8'h00, 8'h00}, // R4 ROM-all page
    {4'd8,  1'b0, 16'hCB00, 1'b1, 8'h00, 8'h00, 8'h00}, // R8 ROM-all window
    {4'd2,  1'b1, 16'hC006, 1'b0, 8'h00, 8'h00, 8'h00}, // R2 ROM-all off
    {4'd9,  1'b0, 16'hC100, 1'b0, 8'h02, 8'h00, 8'h00}, // R9 owner 1
    {4'd8,  1'b0, 16'hC801, 1'b0, 8'h00, 8'h02, 8'h00}, // R8 window -> slot 1
    {4'd10, 1'b0, 16'hC07F, 1'b0, 8'h00, 8'h00, 8'h00}  // R10 below device range
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [15:0] a);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 state", {29'd0, int_all, slot3_card, win_lock}, 32'd0);
    drive(1'b0, 1'b0, 16'hC800);
    chk("R12 idle selects", {7'd0, rom_sel, page_sel, xstrobe_sel, dev_sel}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][41], VEC[i][40:25]);
      checks++;
      if ({rom_sel, page_sel, xstrobe_sel, dev_sel} !== VEC[i][24:0]) begin
        errors++;
        $display("FAIL R%0d row %0d actual=%h expected=%h", VEC[i][45:42], i,
                 {rom_sel, page_sel, xstrobe_sel, dev_sel}, VEC[i][24:0]);
      end
      if (i == 2) chk("R10 dev_reg", {28'd0, dev_reg}, 32'h5);
      if (i == 1) chk("R8 xwin_off", {21'd0, xwin_off}, 32'h000);
      if (i == 9) chk("R4 page_off", {24'd0, page_off}, 32'h10);
      if (i == 16) chk("R8 xwin_off low", {21'd0, xwin_off}, 32'h001);
    end

    // State now: ROM-all 0, slot-3 card 1, lock 0, owner slot 1
    drive(1'b1, 1'b0, 16'hC015);
    chk("R11 read C015", {23'd0, stat_hit, stat_data}, {23'd0, 1'b1, 8'h00});
    drive(1'b1, 1'b0, 16'hC017);
    chk("R11 read C017", {23'd0, stat_hit, stat_data}, {23'd0, 1'b1, 8'h80});
    drive(1'b1, 1'b1, 16'hC00A);
    drive(1'b1, 1'b0, 16'hC007);
    chk("R3 slot-3 switch cleared", {31'd0, slot3_card}, 32'd0);
    drive(1'b0, 1'b0, 16'hC300);
    chk("R2 read of C007 ignored", {31'd0, int_all}, 32'd0);
    chk("R12 invalid C300 selects", {7'd0, rom_sel, page_sel, xstrobe_sel, dev_sel}, 32'd0);
    drive(1'b1, 1'b0, 16'hC300);
    chk("R12 invalid C300 no lock", {31'd0, win_lock}, 32'd0);
    chk("R5 C300 internal", {31'd0, rom_sel}, 32'd1);
    drive(1'b1, 1'b0, 16'hC017);
    chk("R6 lock set", {31'd0, win_lock}, 32'd1);
    chk("R11 slot-3 off", {24'd0, stat_data}, 32'h00);
    drive(1'b1, 1'b0, 16'hC800);
    chk("R8 locked window", {7'd0, rom_sel, page_sel, xstrobe_sel, dev_sel}, {7'd0, 1'b1, 24'd0});
    drive(1'b1, 1'b1, 16'hC007);
    drive(1'b0, 1'b0, 16'h0000);
    chk("R2 write C007", {31'd0, int_all}, 32'd1);

    // Mid-run reset
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 state after reset", {29'd0, int_all, slot3_card, win_lock}, 32'd0);
    drive(1'b1, 1'b0, 16'hC900);
    chk("R1 no owner after reset", {7'd0, rom_sel, page_sel, xstrobe_sel, dev_sel}, 32'd0);
    drive(1'b1, 1'b0, 16'hC500);
    chk("R4 page after reset", {24'd0, page_sel}, 32'h20);
    drive(1'b0, 1'b0, 16'h0000);
    drive(1'b0, 1'b0, 16'h0000);
    finish_run();
  end
endmodule